// File: doc/BRIEF.md
# PCI Interrupt Remapping Router

This block collects the interrupt request levels of the four PCI interrupt pins and of four on-board sources: the IDE controller, the USB controller, the power-management (SCI) source and the monitor/SMBus source. It steers each one onto one of sixteen legacy ISA IRQ lines. Every source has its own routing register. That register holds a disable bit and a 4-bit target IRQ number. The result is a 16-bit IRQ level vector that goes to the legacy interrupt controller.

The IDE controller has two channels. One channel goes through the programmable IDE route. The other channel is wired to a fixed native IRQ line. A swap bit in the IDE routing register exchanges the two channels and moves the fixed line between IRQ 15 and IRQ 14.

Firmware can also raise any IRQ directly through two 8-bit software request registers. When several sources land on the same IRQ line, that line is driven by the OR of all of them.

Top module: `irq_remap_router`

## Requirements
- R1: After reset, every routing register (addresses 0 to 7) reads 0x80 and both software request registers (addresses 8 and 9) read 0x00. With all sources quiet, `irq_out` is 0.
- R2: When bit 7 of a routing register is 0, the source level drives IRQ line number bits 3:0 of that register. When bit 7 is 1, the source has no effect on `irq_out`.
- R3: Writes are masked before they are stored. The PCI pin, USB, SCI and monitor registers keep only bits 7 and 3:0 (mask 0x8F). The IDE register keeps bits 7, 4 and 3:0 (mask 0x9F). The software registers keep all 8 bits. `rd_data` returns the stored value. Addresses 10 to 15 read 0x00, and writes to them change nothing.
- R4: Address map: 0 to 3 route PCI pins A to D (`pci_int_req` bits 0 to 3), 4 routes IDE, 5 routes USB, 6 routes SCI, 7 routes monitor, 8 is the software register for IRQ 0 to 7, and 9 is the software register for IRQ 8 to 15.
- R5: When IDE register bit 4 is 0, IDE channel 0 uses the IDE route and channel 1 drives IRQ 15. When bit 4 is 1, channel 1 uses the IDE route and channel 0 drives IRQ 14. The fixed line ignores IDE register bit 7.
- R6: Bit i of software register 8 drives IRQ i, and bit i of register 9 drives IRQ 8+i. Setting a bit from 0 to 1 asserts that IRQ. Clearing it from 1 to 0 deasserts it.
- R7: Each IRQ line is the OR of every enabled source routed to it, the fixed IDE line if it targets that IRQ, and its software bit.
- R8: A change on a source input reaches `irq_out` after the next rising clock edge. A register write reaches `irq_out` after the second rising edge that follows the write. `rd_data` shows the new value right after the edge that captures the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pci_int_req | input | 4 | PCI interrupt pin levels A..D (bit 0 = A), active high |
| ide_ch_req | input | 2 | IDE channel 0/1 interrupt levels, active high |
| usb_req | input | 1 | USB controller interrupt level |
| sci_req | input | 1 | Power-management SCI interrupt level |
| mon_req | input | 1 | Monitor/SMBus interrupt level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Stored value at rd_addr (combinational) |
| irq_out | output | 16 | IRQ level vector to the interrupt controller |

## Verification
A source level change passes through one register stage, so the bench expects it on `irq_out` one rising edge later. A register write passes through the configuration register and then the output register, so it is due after two edges, while readback is due after one. The bench changes all inputs on the falling edge and holds them over both rising edges of each operation. It compares `rd_data` at the falling edge after the capturing edge and `irq_out` at the falling edge after the second edge. A directed step also samples between the two edges, to confirm that a write does not show up early.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 4;
  localparam int IRQ_W     = 4;
  localparam int NUM_IRQ   = 1 << IRQ_W;
  localparam int NUM_PCI   = 4;
  localparam int NUM_BOARD = 4;
  localparam int NUM_ROUTE = NUM_PCI + NUM_BOARD;
  localparam int NUM_SW    = NUM_IRQ / DATA_W;

  // Route slot positions (also the register addresses)
  localparam int IDX_IDE = NUM_PCI;
  localparam int IDX_USB = NUM_PCI + 1;
  localparam int IDX_SCI = NUM_PCI + 2;
  localparam int IDX_MON = NUM_PCI + 3;
  localparam int SW_BASE = NUM_ROUTE;

  // Field positions inside a routing register
  localparam int BIT_OFF  = 7;
  localparam int BIT_SWAP = 4;

  localparam logic [DATA_W-1:0] MASK_ROUTE = 8'h8F;
  localparam logic [DATA_W-1:0] MASK_IDE   = 8'h9F;
  localparam logic [DATA_W-1:0] RST_ROUTE  = 8'h80;

  // Fixed native IDE line targets
  localparam int NATIVE_PLAIN = 15;
  localparam int NATIVE_SWAP  = 14;

  typedef logic [DATA_W-1:0]  cfg_t;
  typedef logic [NUM_IRQ-1:0] irq_vec_t;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_route_pkg::*;
(
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_en,
  input  logic [ADDR_W-1:0]                    wr_addr,
  input  logic [DATA_W-1:0]                    wr_data,
  input  logic [ADDR_W-1:0]                    rd_addr,
  output logic [DATA_W-1:0]                    rd_data,
  output logic [NUM_ROUTE-1:0][DATA_W-1:0]     route_cfg,
  output logic [NUM_IRQ-1:0]                   sw_vec
);
  logic [NUM_ROUTE-1:0][DATA_W-1:0] cfg_q, cfg_d;
  logic [NUM_SW-1:0][DATA_W-1:0]    sw_q,  sw_d;

  // Next state: masked write into the addressed slot
  always_comb begin
    cfg_d = cfg_q;
    sw_d  = sw_q;
    for (int i = 0; i < NUM_ROUTE; i++) begin
      if (wr_addr == ADDR_W'(i)) begin
        cfg_d[i] = wr_data & ((i == IDX_IDE) ? MASK_IDE : MASK_ROUTE);
      end
    end
    for (int j = 0; j < NUM_SW; j++) begin
      if (wr_addr == ADDR_W'(SW_BASE + j)) begin
        sw_d[j] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= {NUM_ROUTE{RST_ROUTE}};
      sw_q  <= '0;
    end else if (wr_en) begin
      cfg_q <= cfg_d;
      sw_q  <= sw_d;
    end
  end

  // Read mux; unmapped addresses return zero
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_ROUTE; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = cfg_q[i];
    end
    for (int j = 0; j < NUM_SW; j++) begin
      if (rd_addr == ADDR_W'(SW_BASE + j)) rd_data = sw_q[j];
    end
  end

  assign route_cfg = cfg_q;
  assign sw_vec    = sw_q;
endmodule

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
(
  input  logic [DATA_W-1:0]  cfg,
  input  logic               level,
  output logic [NUM_IRQ-1:0] vec
);
  always_comb begin
    vec = '0;
    if (level && !cfg[BIT_OFF]) begin
      vec[cfg[IRQ_W-1:0]] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_remap_router.sv
module irq_remap_router
  import irq_route_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         pci_int_req,
  input  logic [1:0]         ide_ch_req,
  input  logic               usb_req,
  input  logic               sci_req,
  input  logic               mon_req,
  input  logic               wr_en,
  input  logic [3:0]         wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [3:0]         rd_addr,
  output logic [7:0]         rd_data,
  output logic [15:0]        irq_out
);
  logic                             rst_n_s;
  logic [NUM_ROUTE-1:0][DATA_W-1:0] route_cfg;
  logic [NUM_IRQ-1:0]               sw_vec;
  logic                             ide_swap;
  logic [NUM_ROUTE-1:0]             src_lvl;
  logic [NUM_IRQ-1:0]               route_vec [NUM_ROUTE];
  logic [NUM_IRQ-1:0]               native_vec;
  logic [NUM_IRQ-1:0]               irq_d, irq_q;

  irq_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  irq_cfg_regs u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .route_cfg (route_cfg),
    .sw_vec    (sw_vec)
  );

  assign ide_swap = route_cfg[IDX_IDE][BIT_SWAP];

  // Source levels per route slot; swap picks which IDE channel is remapped
  always_comb begin
    src_lvl                = '0;
    src_lvl[NUM_PCI-1:0]   = pci_int_req;
    src_lvl[IDX_IDE]       = ide_swap ? ide_ch_req[1] : ide_ch_req[0];
    src_lvl[IDX_USB]       = usb_req;
    src_lvl[IDX_SCI]       = sci_req;
    src_lvl[IDX_MON]       = mon_req;
  end

  for (genvar g = 0; g < NUM_ROUTE; g++) begin : g_route
    irq_route_decode u_dec (
      .cfg   (route_cfg[g]),
      .level (src_lvl[g]),
      .vec   (route_vec[g])
    );
  end

  // Fixed native IDE line, independent of the route disable bit
  always_comb begin
    native_vec = '0;
    if (ide_swap) native_vec[NATIVE_SWAP]  = ide_ch_req[0];
    else          native_vec[NATIVE_PLAIN] = ide_ch_req[1];
  end

  always_comb begin
    irq_d = sw_vec | native_vec;
    for (int i = 0; i < NUM_ROUTE; i++) begin
      irq_d = irq_d | route_vec[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      irq_q <= '0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/irq_router_checker.sv
module irq_router_checker
  import irq_route_pkg::*;
(
  input logic                             clk,
  input logic                             rst_n_s,
  input logic                             wr_en,
  input logic [ADDR_W-1:0]                wr_addr,
  input logic [DATA_W-1:0]                wr_data,
  input logic [NUM_PCI-1:0]               pci_int_req,
  input logic [1:0]                       ide_ch_req,
  input logic [NUM_ROUTE-1:0][DATA_W-1:0] route_cfg,
  input logic [NUM_IRQ-1:0]               irq_out
);
  logic armed;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) armed <= 1'b0;
    else          armed <= 1'b1;
  end

  // R6: a write to the low software register shows its set bits two edges later
  p_sw_low_r6: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    (wr_en && wr_addr == ADDR_W'(SW_BASE)) |=> ##1
    ((irq_out[DATA_W-1:0] & $past(wr_data, 2)) == $past(wr_data, 2)));

  // R6: same for the high software register
  p_sw_high_r6: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    (wr_en && wr_addr == ADDR_W'(SW_BASE + 1)) |=> ##1
    ((irq_out[NUM_IRQ-1:DATA_W] & $past(wr_data, 2)) == $past(wr_data, 2)));

  // R5: unswapped, channel 1 drives IRQ 15
  p_native_plain_r5: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    ($past(ide_ch_req[1]) && !$past(route_cfg[IDX_IDE][BIT_SWAP])) |->
    irq_out[NATIVE_PLAIN]);

  // R5: swapped, channel 0 drives IRQ 14
  p_native_swap_r5: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    ($past(ide_ch_req[0]) && $past(route_cfg[IDX_IDE][BIT_SWAP])) |->
    irq_out[NATIVE_SWAP]);

  // R2: enabled pin A lands on its programmed IRQ
  p_route_inta_r2: assert property (@(posedge clk) disable iff (!rst_n_s || !armed)
    $past(pci_int_req[0] && !route_cfg[0][BIT_OFF]) |->
    irq_out[$past(route_cfg[0][IRQ_W-1:0])]);
endmodule

bind irq_remap_router irq_router_checker u_irq_router_checker (
  .clk         (clk),
  .rst_n_s     (rst_n_s),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .pci_int_req (pci_int_req),
  .ide_ch_req  (ide_ch_req),
  .route_cfg   (route_cfg),
  .irq_out     (irq_out)
);

// File: tb/test_irq_remap_router.sv
`timescale 1ns/1ps
module test_irq_remap_router;
  logic        clk;
  logic        rst_n;
  logic [3:0]  pci_int_req;
  logic [1:0]  ide_ch_req;
  logic        usb_req, sci_req, mon_req;
  logic        wr_en;
  logic [3:0]  wr_addr, rd_addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic [15:0] irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] sh [0:9];

  irq_remap_router i_irq_remap_router (
    .clk(clk), .rst_n(rst_n), .pci_int_req(pci_int_req), .ide_ch_req(ide_ch_req),
    .usb_req(usb_req), .sci_req(sci_req), .mon_req(mon_req), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%04h expected=%04h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    if (a < 4'd10) return sh[a];
    return 8'h00;
  endfunction

  function automatic void shadow_write(input logic [3:0] a, input logic [7:0] d);
    if (a == 4'd4)      sh[a] = d & 8'h9F;
    else if (a < 4'd8)  sh[a] = d & 8'h8F;
    else if (a < 4'd10) sh[a] = d;
  endfunction

  function automatic logic [15:0] exp_vec();
    logic [15:0] v;
    logic        swp;
    logic [7:0]  lv;
    swp = sh[4][4];
    lv  = {mon_req, sci_req, usb_req, (swp ? ide_ch_req[1] : ide_ch_req[0]), pci_int_req};
    v   = {sh[9], sh[8]};
    for (int i = 0; i < 8; i++) begin
      if (lv[i] && !sh[i][7]) v[sh[i][3:0]] = 1'b1;
    end
    if (swp) v[14] = v[14] | ide_ch_req[0];
    else     v[15] = v[15] | ide_ch_req[1];
    return v;
  endfunction

  // One operation: drive at falling edge, readback after one edge, vector after two
  task automatic op(input logic we, input logic [3:0] a, input logic [7:0] d,
                    input logic [3:0] pci, input logic [1:0] ide,
                    input logic u, input logic s, input logic m, input string tag);
    wr_en = we; wr_addr = a; wr_data = d; rd_addr = a;
    pci_int_req = pci; ide_ch_req = ide; usb_req = u; sci_req = s; mon_req = m;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    if (we) begin
      shadow_write(a, d);
      chk({tag, " readback"}, {8'h00, rd_data}, {8'h00, exp_rd(a)});
    end
    @(posedge clk); @(negedge clk);
    chk({tag, " irq"}, irq_out, exp_vec());
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    pci_int_req = '0; ide_ch_req = '0; usb_req = 0; sci_req = 0; mon_req = 0;
    for (int i = 0; i < 10; i++) sh[i] = (i < 8) ? 8'h80 : 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", irq_out, 16'h0000);
    for (int a = 0; a < 12; a++) begin
      rd_addr = 4'(a);
      #1;
      chk("R1 R4 reset readback", {8'h00, rd_data}, {8'h00, exp_rd(4'(a))});
    end

    // R2 enabled and disabled routes
    op(1, 4'd0, 8'h05, 4'b0001, 2'b00, 0, 0, 0, "R2 enable");
    chk("R2 pin A to IRQ5", irq_out, 16'h0020);
    op(1, 4'd0, 8'h85, 4'b0001, 2'b00, 0, 0, 0, "R2 disable");
    chk("R2 disabled quiet", irq_out, 16'h0000);

    // R3 masks
    op(1, 4'd1, 8'hFF, 4'b0010, 2'b00, 0, 0, 0, "R3 mask pin");
    chk("R3 pin mask 8F", {8'h00, rd_data}, 16'h008F);
    op(1, 4'd4, 8'hFF, 4'b0000, 2'b00, 0, 0, 0, "R3 mask ide");
    chk("R3 ide mask 9F", {8'h00, rd_data}, 16'h009F);

    // R5 swap and fixed line
    op(0, 4'd4, 8'h00, 4'b0000, 2'b01, 0, 0, 0, "R5 swapped fixed");
    chk("R5 ch0 to IRQ14", irq_out, 16'h4000);
    op(1, 4'd4, 8'h80, 4'b0000, 2'b10, 0, 0, 0, "R5 plain fixed");
    chk("R5 ch1 to IRQ15", irq_out, 16'h8000);
    op(0, 4'd4, 8'h00, 4'b0000, 2'b01, 0, 0, 0, "R5 ch0 route off");
    chk("R5 ch0 disabled", irq_out, 16'h0000);
    op(1, 4'd4, 8'h03, 4'b0000, 2'b01, 0, 0, 0, "R5 ch0 routed");
    chk("R5 ch0 to IRQ3", irq_out, 16'h0008);
    op(1, 4'd4, 8'h13, 4'b0000, 2'b01, 0, 0, 0, "R5 swap ch0");
    chk("R5 swap ch0 IRQ14", irq_out, 16'h4000);
    op(0, 4'd4, 8'h00, 4'b0000, 2'b10, 0, 0, 0, "R5 swap ch1");
    chk("R5 swap ch1 IRQ3", irq_out, 16'h0008);
    op(1, 4'd4, 8'h80, 4'b0000, 2'b00, 0, 0, 0, "R5 restore");

    // R6 software requests
    op(1, 4'd8, 8'h81, 4'b0000, 2'b00, 0, 0, 0, "R6 set low");
    chk("R6 low bits 0 7", irq_out, 16'h0081);
    op(1, 4'd8, 8'h01, 4'b0000, 2'b00, 0, 0, 0, "R6 clear bit7");
    chk("R6 bit7 deasserted", irq_out, 16'h0001);
    op(1, 4'd9, 8'h40, 4'b0000, 2'b00, 0, 0, 0, "R6 set high");
    chk("R6 IRQ14 from high", irq_out, 16'h4001);
    op(1, 4'd8, 8'h00, 4'b0000, 2'b00, 0, 0, 0, "R6 clear low");
    op(1, 4'd9, 8'h00, 4'b0000, 2'b00, 0, 0, 0, "R6 clear high");
    chk("R6 all clear", irq_out, 16'h0000);

    // R7 shared IRQ
    op(1, 4'd0, 8'h05, 4'b0001, 2'b00, 0, 0, 0, "R7 pin A");
    op(1, 4'd5, 8'h05, 4'b0001, 2'b00, 1, 0, 0, "R7 usb shared");
    chk("R7 both on IRQ5", irq_out, 16'h0020);
    op(0, 4'd0, 8'h00, 4'b0000, 2'b00, 1, 0, 0, "R7 usb only");
    chk("R7 usb keeps IRQ5", irq_out, 16'h0020);
    op(1, 4'd8, 8'h20, 4'b0000, 2'b00, 0, 0, 0, "R7 sw only");
    chk("R7 sw keeps IRQ5", irq_out, 16'h0020);
    op(1, 4'd8, 8'h00, 4'b0000, 2'b00, 0, 0, 0, "R7 all off");
    chk("R7 all off", irq_out, 16'h0000);

    // R3 unmapped address
    op(1, 4'd11, 8'hFF, 4'b0000, 2'b00, 0, 0, 0, "R3 unmapped");
    chk("R3 unmapped quiet", irq_out, 16'h0000);

    // R8 latency: input one edge, write two edges
    pci_int_req = 4'b0001;
    @(posedge clk); @(negedge clk);
    chk("R8 input after one edge", irq_out, 16'h0020);
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'h06; rd_addr = 4'd0;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    shadow_write(4'd0, 8'h06);
    chk("R8 readback after one edge", {8'h00, rd_data}, 16'h0006);
    chk("R8 irq not yet moved", irq_out, 16'h0020);
    @(posedge clk); @(negedge clk);
    chk("R8 irq after two edges", irq_out, 16'h0040);

    // R4 R7 random mix against the model
    for (int n = 0; n < 400; n++) begin
      op(($urandom % 4) != 0, 4'($urandom % 12), 8'($urandom),
         4'($urandom), 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
         "R4 R7 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule